// File: doc/BRIEF.md
# Return Address Stack with Flag Save

This block keeps return addresses for a small 8-bit microcontroller and picks the program counter for the next instruction whenever control flow goes through the stack. A call request, taken only when its condition holds, saves the address after the current instruction and sends execution to a supplied target. An interrupt request saves the same address together with the carry and zero flags and sends execution to a fixed vector. A return request takes the newest entry and jumps to it. An interrupt-return request does the same and also hands back the saved flags, so the core can restore them.

The storage depth is a power-of-two parameter, normally 8, 16 or 32 entries. There is no overflow or underflow detection. The pointer wraps around the depth, so a push past the top overwrites the oldest entry, and a pop from an empty stack rereads the highest slot. Software is expected to limit nesting. All outputs are combinational from the requests and the current stack top. The stack itself changes on the next rising clock edge.

Top module: `callStack`

## Requirements
- R1: While reset is low and after it is released, the pointer is 0 and every entry holds address 0 with both flags 0.
- R2: A taken call saves `pcIn + 1` (modulo 2^AW) with both flags stored as 0, drives `nextPc = targetIn` and raises `pcLoad`.
- R3: `callCond` selects when a call is taken: 0 always, 1 carry set, 2 carry clear, 3 zero set, 4 zero clear, 5 to 7 never. An untaken call leaves the stack unchanged, holds `pcLoad` low and drives `nextPc = pcIn + 1`.
- R4: An interrupt is always taken. It saves `pcIn + 1` together with `carryIn` and `zeroIn`, drives `nextPc` to the vector (default 0) and raises `pcLoad`.
- R5: A return drives `nextPc` to the newest saved address and raises `pcLoad`. It keeps `flagsLoad` low and passes `carryIn`/`zeroIn` through unchanged to `carryOut`/`zeroOut`.
- R6: An interrupt return drives `nextPc` to the newest saved address, raises `pcLoad` and `flagsLoad`, and drives `carryOut`/`zeroOut` from the saved flags.
- R7: The flag inputs present during a plain call are ignored. An interrupt return that takes an entry saved by a call restores carry 0 and zero 0.
- R8: Entries come back in last-in first-out order across nested calls and interrupts.
- R9: After more than DEPTH pushes, the pointer has wrapped, so the oldest entries are overwritten and later pops reread the newer ones.
- R10: A pop on an empty stack reads slot DEPTH-1 and leaves the pointer at DEPTH-1.
- R11: If requests arrive together, the winner is chosen in this order: interrupt first, then a taken call, then interrupt return, then return. Only one push or pop happens in a cycle.
- R12: With no taken request, `pcLoad` and `flagsLoad` are low, `nextPc = pcIn + 1`, the flags pass through, and the stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pcIn | input | AW | Address of the current instruction |
| targetIn | input | AW | Call target address |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| callReq | input | 1 | Call request |
| callCond | input | 3 | Call condition code (see R3) |
| irqReq | input | 1 | Interrupt entry request |
| retReq | input | 1 | Plain return request |
| iretReq | input | 1 | Interrupt return request |
| nextPc | output | AW | Program counter for the next instruction |
| pcLoad | output | 1 | High when nextPc comes from a call, vector or popped entry |
| carryOut | output | 1 | Carry for the core: restored on interrupt return, else carryIn |
| zeroOut | output | 1 | Zero for the core: restored on interrupt return, else zeroIn |
| flagsLoad | output | 1 | High when carryOut/zeroOut come from the stack |

## Verification
The assertions assume that every request input and the flag inputs are at known values in each cycle after reset. They also assume the requests are held low while reset is low, because the back-to-back push/pop checks look one cycle into the past. The bench drives every input to 0 before and during reset, and it changes inputs only on the falling clock edge. The priority stimulus deliberately raises several requests in the same cycle, which the control logic is built to resolve.

// File: rtl/callStackPkg.sv
package callStackPkg;

  // Call condition codes (R3)
  localparam logic [2:0] CondAlways    = 3'd0;
  localparam logic [2:0] CondCarrySet  = 3'd1;
  localparam logic [2:0] CondCarryClr  = 3'd2;
  localparam logic [2:0] CondZeroSet   = 3'd3;
  localparam logic [2:0] CondZeroClr   = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic saveFlags;
    logic restoreFlags;
    logic jumpTarget;
    logic jumpVector;
    logic jumpPopped;
  } stackStrobe_t;

endpackage

// File: rtl/callStackCtrl.sv
module callStackCtrl
  import callStackPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         callReq,
  input  logic [2:0]   callCond,
  input  logic         irqReq,
  input  logic         retReq,
  input  logic         iretReq,
  input  logic         carryIn,
  input  logic         zeroIn,
  output stackStrobe_t strobe
);

  logic condMet;
  logic callTaken;

  always_comb begin
    unique case (callCond)
      CondAlways:   condMet = 1'b1;
      CondCarrySet: condMet = carryIn;
      CondCarryClr: condMet = !carryIn;
      CondZeroSet:  condMet = zeroIn;
      CondZeroClr:  condMet = !zeroIn;
      default:      condMet = 1'b0;
    endcase
  end

  assign callTaken = callReq && condMet;

  // Fixed priority: interrupt, taken call, interrupt return, return
  always_comb begin
    strobe = '0;
    if (irqReq) begin
      strobe.push       = 1'b1;
      strobe.saveFlags  = 1'b1;
      strobe.jumpVector = 1'b1;
    end else if (callTaken) begin
      strobe.push       = 1'b1;
      strobe.jumpTarget = 1'b1;
    end else if (iretReq) begin
      strobe.pop          = 1'b1;
      strobe.restoreFlags = 1'b1;
      strobe.jumpPopped   = 1'b1;
    end else if (retReq) begin
      strobe.pop        = 1'b1;
      strobe.jumpPopped = 1'b1;
    end
  end

  // R11
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && (retReq || iretReq || callReq)) |-> (strobe.push && strobe.saveFlags && !strobe.pop));

  // R3
  untaken_call_chk: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && callCond > 3'd4 && !irqReq && !retReq && !iretReq) |-> (strobe == '0));

endmodule

// File: rtl/callStackData.sv
module callStackData
  import callStackPkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter int          AW     = 12,
  parameter logic [AW-1:0] VECTOR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  stackStrobe_t  strobe,
  input  logic [AW-1:0] pcIn,
  input  logic [AW-1:0] targetIn,
  input  logic          carryIn,
  input  logic          zeroIn,
  output logic [AW-1:0] nextPc,
  output logic          pcLoad,
  output logic          carryOut,
  output logic          zeroOut,
  output logic          flagsLoad
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp;       // next free slot
  logic [PTR_W-1:0] topIdx;
  logic [AW-1:0]    addrMem [DEPTH];
  logic [1:0]       flagMem [DEPTH];  // {carry, zero}
  logic [AW-1:0]    retAddr;
  logic [AW-1:0]    topAddr;
  logic [1:0]       topFlags;
  logic [1:0]       pushFlags;

  assign topIdx    = sp - 1'b1;
  assign retAddr   = pcIn + AW'(1);
  assign topAddr   = addrMem[topIdx];
  assign topFlags  = flagMem[topIdx];
  assign pushFlags = strobe.saveFlags ? {carryIn, zeroIn} : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addrMem[i] <= '0;
        flagMem[i] <= '0;
      end
    end else if (strobe.push) begin
      addrMem[sp] <= retAddr;
      flagMem[sp] <= pushFlags;
      sp          <= sp + 1'b1;
    end else if (strobe.pop) begin
      sp <= sp - 1'b1;
    end
  end

  always_comb begin
    if (strobe.jumpVector)      nextPc = VECTOR;
    else if (strobe.jumpTarget) nextPc = targetIn;
    else if (strobe.jumpPopped) nextPc = topAddr;
    else                        nextPc = retAddr;
  end

  assign pcLoad    = strobe.jumpVector || strobe.jumpTarget || strobe.jumpPopped;
  assign flagsLoad = strobe.restoreFlags;
  assign carryOut  = strobe.restoreFlags ? topFlags[1] : carryIn;
  assign zeroOut   = strobe.restoreFlags ? topFlags[0] : zeroIn;

  // R9
  push_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (sp == PTR_W'($past(sp) + 1'b1)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.push && !strobe.pop) |=> $stable(sp));

  // R8
  lifo_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.jumpPopped && $past(strobe.push)) |-> (nextPc == $past(retAddr)));

  // R7
  call_flags_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.restoreFlags && $past(strobe.push && !strobe.saveFlags))
      |-> (!carryOut && !zeroOut));

endmodule

// File: rtl/callStack.sv
module callStack
  import callStackPkg::*;
#(
  parameter int            DEPTH  = 16,
  parameter int            AW     = 12,
  parameter logic [AW-1:0] VECTOR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] pcIn,
  input  logic [AW-1:0] targetIn,
  input  logic          carryIn,
  input  logic          zeroIn,
  input  logic          callReq,
  input  logic [2:0]    callCond,
  input  logic          irqReq,
  input  logic          retReq,
  input  logic          iretReq,
  output logic [AW-1:0] nextPc,
  output logic          pcLoad,
  output logic          carryOut,
  output logic          zeroOut,
  output logic          flagsLoad
);

  stackStrobe_t strobe;

  callStackCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .callReq  (callReq),
    .callCond (callCond),
    .irqReq   (irqReq),
    .retReq   (retReq),
    .iretReq  (iretReq),
    .carryIn  (carryIn),
    .zeroIn   (zeroIn),
    .strobe   (strobe)
  );

  callStackData #(
    .DEPTH  (DEPTH),
    .AW     (AW),
    .VECTOR (VECTOR)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pcIn      (pcIn),
    .targetIn  (targetIn),
    .carryIn   (carryIn),
    .zeroIn    (zeroIn),
    .nextPc    (nextPc),
    .pcLoad    (pcLoad),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut),
    .flagsLoad (flagsLoad)
  );

endmodule

// File: tb/callStack_bench.sv
module callStack_bench;

  localparam int DEPTH = 8;
  localparam int AW    = 12;
  localparam int AMASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic [AW-1:0] targetIn = '0;
  logic          carryIn = 1'b0;
  logic          zeroIn = 1'b0;
  logic          callReq = 1'b0;
  logic [2:0]    callCond = '0;
  logic          irqReq = 1'b0;
  logic          retReq = 1'b0;
  logic          iretReq = 1'b0;
  logic [AW-1:0] nextPc;
  logic          pcLoad;
  logic          carryOut;
  logic          zeroOut;
  logic          flagsLoad;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Behavioural reference state
  int mAddr [DEPTH];
  int mFlag [DEPTH];
  int mSp;

  always #5 clk = ~clk;

  callStack #(.DEPTH(DEPTH), .AW(AW)) u_callStack (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .targetIn(targetIn),
    .carryIn(carryIn), .zeroIn(zeroIn), .callReq(callReq), .callCond(callCond),
    .irqReq(irqReq), .retReq(retReq), .iretReq(iretReq),
    .nextPc(nextPc), .pcLoad(pcLoad), .carryOut(carryOut),
    .zeroOut(zeroOut), .flagsLoad(flagsLoad)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    {callReq, irqReq, retReq, iretReq} = '0;
    callCond = '0; carryIn = 0; zeroIn = 0; pcIn = '0; targetIn = '0;
    for (int i = 0; i < DEPTH; i++) begin mAddr[i] = 0; mFlag[i] = 0; end
    mSp = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One cycle: drive, compare against the model, advance the model
  task automatic step(input string tag, input int pc, input int tgt, input bit c, input bit z,
                      input bit cr, input int cc, input bit ir, input bit rr, input bit ie);
    bit condOk, callOk, doPush, doPop, restore, load;
    int expPc, top, saveF;
    @(negedge clk);
    pcIn = AW'(pc); targetIn = AW'(tgt); carryIn = c; zeroIn = z;
    callReq = cr; callCond = 3'(cc); irqReq = ir; retReq = rr; iretReq = ie;
    #1;
    case (cc)
      0: condOk = 1;
      1: condOk = c;
      2: condOk = !c;
      3: condOk = z;
      4: condOk = !z;
      default: condOk = 0;
    endcase
    callOk  = cr && condOk;
    doPush  = ir || callOk;
    doPop   = !doPush && (ie || rr);
    restore = !doPush && ie;
    top     = (mSp + DEPTH - 1) % DEPTH;
    load    = doPush || doPop;
    if (ir)          expPc = 0;
    else if (callOk) expPc = tgt;
    else if (doPop)  expPc = mAddr[top];
    else             expPc = (pc + 1) & AMASK;
    check(tag, "nextPc", int'(nextPc), expPc);
    check(tag, "pcLoad", int'(pcLoad), int'(load));
    check(tag, "flagsLoad", int'(flagsLoad), int'(restore));
    check(tag, "carryOut", int'(carryOut), restore ? (mFlag[top] >> 1) & 1 : int'(c));
    check(tag, "zeroOut", int'(zeroOut), restore ? mFlag[top] & 1 : int'(z));
    if (doPush) begin
      saveF = ir ? (int'(c) * 2 + int'(z)) : 0;
      mAddr[mSp] = (pc + 1) & AMASK;
      mFlag[mSp] = saveF;
      mSp = (mSp + 1) % DEPTH;
    end else if (doPop) begin
      mSp = top;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 / R12: idle after reset
    step("R12", 16'h010, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 / R10: return from empty reads zeroed slot DEPTH-1
    step("R10", 16'h020, 0, 1, 1, 0, 0, 0, 1, 0);
    step("R1",  16'h030, 0, 1, 0, 0, 0, 0, 0, 1);

    doReset();
    // R2 / R8: nested calls then returns
    step("R2", 100, 500, 1, 1, 1, 0, 0, 0, 0);
    step("R2", 500, 700, 0, 1, 1, 0, 0, 0, 0);
    step("R2", 700, 900, 1, 0, 1, 0, 0, 0, 0);
    step("R8", 900, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5", 701, 0, 1, 0, 0, 0, 0, 1, 0);
    step("R8", 501, 0, 0, 1, 0, 0, 0, 1, 0);
    // R2: address wrap of pc+1
    step("R2", AMASK, 33, 0, 0, 1, 0, 0, 0, 0);
    step("R2", 33, 0, 0, 0, 0, 0, 0, 1, 0);

    // R3: every condition code with both flag polarities
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 2; f++) begin
        step("R3", 200 + cc * 4 + f, 1000 + cc, f[0], f[0], 1, cc, 0, 0, 0);
        step("R3", 50, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end
    // unwind whatever was pushed
    for (int i = 0; i < 8; i++) step("R8", 60, 0, 0, 0, 0, 0, 0, 1, 0);

    doReset();
    // R4 / R6: interrupt saves flags, interrupt return restores them
    step("R4", 300, 0, 1, 0, 0, 0, 1, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0, 1, 0, 0);
    step("R6", 5, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 7, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: plain return after interrupt leaves flags alone
    step("R4", 400, 0, 1, 1, 0, 0, 1, 0, 0);
    step("R5", 9, 0, 0, 0, 0, 0, 0, 1, 0);
    // R7: call with flags high, interrupt return gives flags 0
    step("R7", 450, 800, 1, 1, 1, 0, 0, 0, 0);
    step("R7", 800, 0, 1, 1, 0, 0, 0, 0, 1);

    // R11: simultaneous requests
    step("R11", 600, 610, 1, 1, 1, 0, 1, 1, 1);
    step("R11", 620, 630, 0, 0, 1, 0, 0, 1, 1);
    step("R11", 640, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R11", 650, 660, 0, 0, 1, 1, 0, 1, 0);
    step("R11", 670, 0, 1, 1, 0, 0, 0, 1, 1);

    doReset();
    // R9: overflow wrap with DEPTH+3 pushes, then pops past empty
    for (int i = 0; i < DEPTH + 3; i++)
      step("R9", 1000 + 10 * i, 2000 + i, i[0], i[1], (i % 3) != 2, 0, (i % 3) == 2, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++)
      step("R9", 3000 + i, 0, 0, 0, 0, 0, 0, !i[0], i[0]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule